// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register-transfer datapath of a small accumulator processor. All transfers go over one shared bus. In each cycle the control unit names at most one source, and any register whose load strobe is raised captures the bus value at the clock edge. The registers on the bus are:

- program counter
- accumulator
- instruction register
- return-address register
- memory data input, which acts as a source only

The memory-address register and the ALU argument register can only be loaded; they never drive the bus. An ALU with four operations combines the argument register with the bus. A result buffer captures the ALU output in every cycle in which the bus is valid, and it drives the bus only when the control unit asks for it.

A validity check counts the active bus sources. When two or more sources are active in the same cycle, the bus reads as zero and every bus-fed register keeps its value, the buffer included.

An interrupt-acknowledge bit is kept as a J-K flip-flop. The return-register load strobe sets it and the return-register drive strobe clears it. The block also produces:

- the memory interface signals: write flag, request flag and write data
- the opcode field for the control unit's sequencer
- the address field for the memory
- an all-zero flag for the accumulator

Top module: `acc_bus_datapath`

## Requirements
- R1: When exactly one source drives the bus, every register whose load strobe is high holds that bus value after the next rising clock edge.
- R2: When two or more of the six sources (mem_rd, pc_drv, acc_drv, ir_drv, ret_drv, buf_drv) are high in a cycle, the bus reads as zero and no register changes at that edge (program counter, accumulator, instruction, return, memory address, argument, buffer).
- R3: When no source is high, the bus reads as zero, and a register loaded in that cycle becomes zero.
- R4: In every cycle with a valid bus, the buffer captures the ALU result. The buffer reaches the bus only while buf_drv is high.
- R5: The ALU operation is selected by alu_op: 00 passes the bus, 01 gives bus+1, 10 gives argument+bus, 11 gives argument-bus, all modulo 2^DW.
- R6: int_ack is set when ret_ld is high alone, cleared when ret_drv is high alone, inverted when both are high, and held otherwise. This happens whether or not the bus is valid.
- R7: mem_write follows mem_wr. mem_req is high when mem_wr or mem_rd is high.
- R8: mem_dout equals the bus while mem_wr is high and is all zeros otherwise.
- R9: A register whose load strobe is low keeps its value across the clock edge.
- R10: opc_fld is the top OPCW bits of the instruction register. addr_fld is the low DW-OPCW bits of the memory-address register.
- R11: acc_zero is high exactly when every accumulator bit is zero.
- R12: While rst_n is low, every register and int_ack return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_rd | input | 1 | Memory data input drives the bus |
| mem_wr | input | 1 | Memory write this cycle |
| mar_ld | input | 1 | Load memory-address register |
| pc_ld | input | 1 | Load program counter |
| pc_drv | input | 1 | Program counter drives the bus |
| acc_ld | input | 1 | Load accumulator |
| acc_drv | input | 1 | Accumulator drives the bus |
| ir_ld | input | 1 | Load instruction register |
| ir_drv | input | 1 | Instruction register drives the bus |
| ret_ld | input | 1 | Load return register; sets int_ack |
| ret_drv | input | 1 | Return register drives the bus; clears int_ack |
| arg_ld | input | 1 | Load ALU argument register |
| buf_drv | input | 1 | Result buffer drives the bus |
| alu_op | input | 2 | ALU operation select |
| mem_din | input | DW | Data from memory |
| addr_fld | output | DW-OPCW | Address field of the memory-address register |
| opc_fld | output | OPCW | Opcode field of the instruction register |
| acc_zero | output | 1 | Accumulator is zero |
| int_ack | output | 1 | Interrupt-acknowledge flag |
| mem_dout | output | DW | Write data to memory |
| mem_write | output | 1 | Memory write flag |
| mem_req | output | 1 | Memory request flag |

## Verification
Two functions can fall in the same cycle. One is the R2 rule that blocks every bus-fed write when sources collide. The other is the J-K acknowledge update, which still acts in that cycle, as does the buffer's own load. The random stimulus raises two drive strobes together in some cycles while it also pulses the return-register strobes. A bench model then predicts the registers: frozen registers, a frozen buffer and a still-moving int_ack. These are judged by reading each register back through the memory write data.

// File: rtl/acc_bus_datapath.sv
module acc_bus_datapath #(
  parameter int DW   = 16,
  parameter int OPCW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mem_rd,
  input  logic            mem_wr,
  input  logic            mar_ld,
  input  logic            pc_ld,
  input  logic            pc_drv,
  input  logic            acc_ld,
  input  logic            acc_drv,
  input  logic            ir_ld,
  input  logic            ir_drv,
  input  logic            ret_ld,
  input  logic            ret_drv,
  input  logic            arg_ld,
  input  logic            buf_drv,
  input  logic [1:0]      alu_op,
  input  logic [DW-1:0]   mem_din,
  output logic [DW-OPCW-1:0] addr_fld,
  output logic [OPCW-1:0] opc_fld,
  output logic            acc_zero,
  output logic            int_ack,
  output logic [DW-1:0]   mem_dout,
  output logic            mem_write,
  output logic            mem_req
);
  localparam int AW = DW - OPCW;

  logic [DW-1:0] mar_q, pc_q, acc_q, ir_q, ret_q, arg_q, buf_q;
  logic          iack_q;
  logic [2:0]    src_cnt;
  logic          bus_ok;
  logic [DW-1:0] bus_any, bus, alu;

  assign src_cnt = 3'(mem_rd) + 3'(pc_drv) + 3'(acc_drv) + 3'(ir_drv)
                 + 3'(ret_drv) + 3'(buf_drv);
  assign bus_ok  = (src_cnt <= 3'd1);

  assign bus_any = ({DW{mem_rd}}  & mem_din) | ({DW{pc_drv}}  & pc_q)
                 | ({DW{acc_drv}} & acc_q)   | ({DW{ir_drv}}  & ir_q)
                 | ({DW{ret_drv}} & ret_q)   | ({DW{buf_drv}} & buf_q);
  assign bus     = bus_ok ? bus_any : '0;

  always_comb begin
    case (alu_op)
      2'b00:   alu = bus;
      2'b01:   alu = bus + DW'(1);
      2'b10:   alu = arg_q + bus;
      default: alu = arg_q - bus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q  <= '0;
      pc_q   <= '0;
      acc_q  <= '0;
      ir_q   <= '0;
      ret_q  <= '0;
      arg_q  <= '0;
      buf_q  <= '0;
      iack_q <= 1'b0;
    end else begin
      if (bus_ok) begin
        if (mar_ld) mar_q <= bus;
        if (pc_ld)  pc_q  <= bus;
        if (acc_ld) acc_q <= bus;
        if (ir_ld)  ir_q  <= bus;
        if (ret_ld) ret_q <= bus;
        if (arg_ld) arg_q <= bus;
        buf_q <= alu;
      end
      case ({ret_ld, ret_drv})
        2'b10:   iack_q <= 1'b1;
        2'b01:   iack_q <= 1'b0;
        2'b11:   iack_q <= ~iack_q;
        default: iack_q <= iack_q;
      endcase
    end
  end

  assign addr_fld  = mar_q[AW-1:0];
  assign opc_fld   = ir_q[DW-1 -: OPCW];
  assign acc_zero  = ~|acc_q;
  assign int_ack   = iack_q;
  assign mem_write = mem_wr;
  assign mem_req   = mem_wr | mem_rd;
  assign mem_dout  = mem_wr ? bus : '0;
endmodule

// File: rtl/acc_bus_datapath_chk.sv
module acc_bus_datapath_chk #(
  parameter int DW = 16,
  parameter int AW = 13,
  parameter int OPCW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_ok,
  input logic [DW-1:0]   bus,
  input logic [DW-1:0]   alu,
  input logic            pc_ld,
  input logic            ret_ld,
  input logic            ret_drv,
  input logic [DW-1:0]   pc_q,
  input logic [DW-1:0]   buf_q,
  input logic            iack,
  input logic [AW-1:0]   addr_fld,
  input logic [OPCW-1:0] opc_fld
);
  AST_BUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ok && pc_ld |=> pc_q == $past(bus)); // R1
  AST_CONFLICT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok |=> $stable(addr_fld) && $stable(opc_fld) && $stable(pc_q) && $stable(buf_q)); // R2
  AST_BUF_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ok |=> buf_q == $past(alu)); // R4
  AST_ACK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ld && !ret_drv |=> iack); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ret_drv && !ret_ld |=> !iack); // R6
  AST_ACK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ld && ret_drv |=> iack != $past(iack)); // R6
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_ld |=> $stable(pc_q)); // R9
endmodule

bind acc_bus_datapath acc_bus_datapath_chk #(.DW(DW), .AW(DW-OPCW), .OPCW(OPCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ok(bus_ok), .bus(bus), .alu(alu),
  .pc_ld(pc_ld), .ret_ld(ret_ld), .ret_drv(ret_drv), .pc_q(pc_q),
  .buf_q(buf_q), .iack(iack_q), .addr_fld(addr_fld), .opc_fld(opc_fld)
);

// File: tb/tb_acc_bus_datapath.sv
`timescale 1ns/1ps
module tb_acc_bus_datapath;
  localparam int DW = 16, OPCW = 3, AW = DW - OPCW;

  logic clk = 0, rst_n = 0;
  logic mem_rd, mem_wr, mar_ld, pc_ld, pc_drv, acc_ld, acc_drv, ir_ld, ir_drv;
  logic ret_ld, ret_drv, arg_ld, buf_drv;
  logic [1:0] alu_op;
  logic [DW-1:0] mem_din;
  logic [AW-1:0] addr_fld;
  logic [OPCW-1:0] opc_fld;
  logic acc_zero, int_ack, mem_write, mem_req;
  logic [DW-1:0] mem_dout;

  int checks = 0, errors = 0;
  logic [DW-1:0] m_mar, m_pc, m_acc, m_ir, m_ret, m_arg, m_buf;
  logic m_iack;

  always #2 clk = ~clk;

  acc_bus_datapath #(.DW(DW), .OPCW(OPCW)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] bus_val();
    int n = int'(mem_rd) + int'(pc_drv) + int'(acc_drv) + int'(ir_drv) + int'(ret_drv) + int'(buf_drv);
    if (n != 1) return '0;
    if (mem_rd)  return mem_din;
    if (pc_drv)  return m_pc;
    if (acc_drv) return m_acc;
    if (ir_drv)  return m_ir;
    if (ret_drv) return m_ret;
    return m_buf;
  endfunction

  function automatic logic ok_val();
    return (int'(mem_rd) + int'(pc_drv) + int'(acc_drv) + int'(ir_drv) + int'(ret_drv) + int'(buf_drv)) <= 1;
  endfunction

  function automatic logic [DW-1:0] alu_val(logic [DW-1:0] b);
    case (alu_op)
      2'b00: return b;
      2'b01: return b + 1'b1;
      2'b10: return m_arg + b;
      default: return m_arg - b;
    endcase
  endfunction

  task automatic idle();
    {mem_rd, mem_wr, mar_ld, pc_ld, pc_drv, acc_ld, acc_drv, ir_ld, ir_drv} = '0;
    {ret_ld, ret_drv, arg_ld, buf_drv} = '0;
    alu_op = 2'b00;
    mem_din = '0;
  endtask

  task automatic step(string tag);
    logic [DW-1:0] b;
    #1;
    b = bus_val();
    check({tag, " R8 dout"}, 32'(mem_dout), 32'(mem_wr ? b : '0));
    check({tag, " R7 write"}, 32'(mem_write), 32'(mem_wr));
    check({tag, " R7 req"}, 32'(mem_req), 32'(mem_wr | mem_rd));
    check({tag, " R10 addr"}, 32'(addr_fld), 32'(m_mar[AW-1:0]));
    check({tag, " R10 opc"}, 32'(opc_fld), 32'(m_ir[DW-1 -: OPCW]));
    check({tag, " R11 zero"}, 32'(acc_zero), 32'(m_acc == '0));
    check({tag, " R6 iack"}, 32'(int_ack), 32'(m_iack));
    if (ok_val()) begin
      if (mar_ld) m_mar = b;
      if (pc_ld)  m_pc  = b;
      if (acc_ld) m_acc = b;
      if (ir_ld)  m_ir  = b;
      if (ret_ld) m_ret = b;
      if (arg_ld) m_arg = b;
      m_buf = alu_val(b);
    end
    case ({ret_ld, ret_drv})
      2'b10: m_iack = 1'b1;
      2'b01: m_iack = 1'b0;
      2'b11: m_iack = ~m_iack;
      default: ;
    endcase
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B));
    idle();
    {m_mar, m_pc, m_acc, m_ir, m_ret, m_arg, m_buf} = '0;
    m_iack = 0;
    mem_din = 16'hFFFF; pc_ld = 1; mem_rd = 1; ret_ld = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    // R12 reset state, peeked through the write data
    step("R12 idle");
    pc_drv = 1; mem_wr = 1; step("R12 pc");
    ret_drv = 1; mem_wr = 1; step("R12 ret");
    buf_drv = 1; mem_wr = 1; step("R12 buf");
    // R1 single source loads several registers
    mem_rd = 1; mem_din = 16'hA5C3; acc_ld = 1; pc_ld = 1; step("R1 load");
    acc_drv = 1; mem_wr = 1; step("R1 acc");
    pc_drv = 1; mem_wr = 1; step("R1 pc");
    // R11 zero flag
    mem_rd = 1; mem_din = 16'h0000; acc_ld = 1; step("R11 clear");
    step("R11 zero");
    // R5 ALU ops
    mem_rd = 1; mem_din = 16'd5; arg_ld = 1; step("R5 arg");
    mem_rd = 1; mem_din = 16'd7; alu_op = 2'b10; step("R5 add");
    buf_drv = 1; mem_wr = 1; step("R5 add read");
    mem_rd = 1; mem_din = 16'd9; alu_op = 2'b11; step("R5 sub");
    buf_drv = 1; mem_wr = 1; step("R5 sub read");
    mem_rd = 1; mem_din = 16'hFFFF; alu_op = 2'b01; step("R5 inc");
    buf_drv = 1; mem_wr = 1; step("R5 inc read");
    mem_rd = 1; mem_din = 16'h1234; alu_op = 2'b00; step("R5 pass");
    buf_drv = 1; mem_wr = 1; step("R4 buf drive");
    // R2 conflict: nothing loads, bus is zero
    pc_drv = 1; acc_drv = 1; mem_wr = 1; pc_ld = 1; mar_ld = 1; alu_op = 2'b01; step("R2 conflict");
    pc_drv = 1; mem_wr = 1; step("R2 pc kept");
    buf_drv = 1; mem_wr = 1; step("R2 buf kept");
    // R3 no source
    acc_ld = 1; mar_ld = 1; step("R3 empty");
    acc_drv = 1; mem_wr = 1; step("R3 acc");
    // R6 acknowledge flag
    ret_ld = 1; step("R6 set");
    step("R6 hold");
    ret_ld = 1; ret_drv = 1; step("R6 toggle");
    ret_ld = 1; ret_drv = 1; pc_drv = 1; step("R6 toggle conflict");
    ret_drv = 1; step("R6 clear");
    // R10 fields
    mem_rd = 1; mem_din = 16'hE001; ir_ld = 1; mar_ld = 1; step("R10 load");
    mem_rd = 1; mem_din = 16'h5FFF; mar_ld = 1; step("R10 addr");
    step("R9 hold");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r = $urandom();
      mem_din = DW'($urandom());
      alu_op = r[1:0];
      mar_ld = r[2]; pc_ld = r[3] & r[4]; acc_ld = r[5]; ir_ld = r[6] & r[7];
      ret_ld = r[8] & r[9]; arg_ld = r[10]; mem_wr = r[11];
      case (r[14:12])
        3'd0: mem_rd = 1;
        3'd1: pc_drv = 1;
        3'd2: acc_drv = 1;
        3'd3: ir_drv = 1;
        3'd4: ret_drv = 1;
        3'd5: buf_drv = 1;
        default: ;
      endcase
      if (r[17:15] == 3'd0) begin buf_drv = 1; ret_drv = r[18]; end
      step("R9 random");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule